// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in a receive path between the byte stream coming off the line and the receive DMA. It watches each frame byte by byte. It captures the six-byte destination field and counts the frame length. It then decides whether the frame should be kept or thrown away. An early header verdict comes out as soon as the destination is complete. A final verdict, which also takes the frame length into account, comes out once the last byte has passed.

Frames are classified as broadcast (all ones), multicast (low bit of the first destination byte set, but not all ones) or unicast. Broadcast and multicast each have a drop-enable bit and a don't-care bit. The don't-care bit overrides the drop-enable bit. Unicast frames pass only when the destination equals the programmed station address. A small configuration write port holds the station address, the length limit and the two policy words.

Top module: `rxf_dst_filter`

## Requirements
- R1: After reset the length limit is 0x600, the don't-care word is 0x3FFFF, the drop-enable word and the station address are zero, and no strobe is raised.
- R2: Configuration writes use `cfg_addr` 0 for station octets 1–4 (octet 1 in bits [31:24] down to octet 4 in [7:0]), 1 for octets 5–6 (bits [31:24] and [23:16]), 2 for the length limit, 3 for the drop-enable word and 4 for the don't-care word. Octet 1 is the first destination byte received.
- R3: A unicast destination passes only when all six bytes equal the station address.
- R4: A broadcast frame is dropped only when bit 9 of the drop-enable word is set and bit 9 of the don't-care word is clear.
- R5: A multicast frame follows the same rule as R4, using bit 8 of each word.
- R6: The broadcast test is applied before the multicast test, so an all-ones destination never follows the multicast bits.
- R7: A frame whose byte count exceeds bits [15:0] of the length limit is dropped; a frame exactly at the limit may pass.
- R8: A frame shorter than six bytes raises no header strobe and its final verdict is a drop.
- R9: `hdr_vld` pulses for one cycle, in the cycle after the sixth byte is taken. `dec_vld` pulses for one cycle, in the cycle after the end-of-frame byte is taken.
- R10: `dec_kind` reports 0 for unicast, 1 for multicast and 2 for broadcast with the final verdict of a frame of at least six bytes.
- R11: Bytes offered without a start marker while no frame is open are ignored and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select (see R2) |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Frame byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| hdr_vld | output | 1 | Header verdict strobe |
| hdr_pass | output | 1 | Destination accepted (with `hdr_vld`) |
| dec_vld | output | 1 | Final verdict strobe |
| dec_pass | output | 1 | Frame accepted (with `dec_vld`) |
| dec_kind | output | 2 | Destination class (see R10) |

## Verification
The assertions assume that every frame opens with `in_sop` on its first byte and closes with `in_eop`. They also assume that the policy words and length limit are not rewritten while a frame is in flight, since the classifier reads them live. The stimulus follows both rules. Configuration writes are issued only between frames, with idle gaps after each end-of-frame byte. The stray-byte case sends bytes with no start marker only while no frame is open.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      KIND_UNI   = 2'd0,
      KIND_MULTI = 2'd1,
      KIND_BCAST = 2'd2
   } rxf_kind_e;

   localparam logic [2:0] CFG_STA_HI = 3'd0;
   localparam logic [2:0] CFG_STA_LO = 3'd1;
   localparam logic [2:0] CFG_MAXLEN = 3'd2;
   localparam logic [2:0] CFG_DROP   = 3'd3;
   localparam logic [2:0] CFG_DCARE  = 3'd4;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
   parameter logic [31:0] MAXLEN_RST = 32'h0000_0600,
   parameter logic [31:0] DCARE_RST  = 32'h0003_FFFF,
   parameter int          BC_BIT     = 9,
   parameter int          MC_BIT     = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output logic [47:0] station,
   output logic [15:0] max_len,
   output logic [1:0]  drop_en,
   output logic [1:0]  dcare
);
   import rxf_pkg::*;

   logic [31:0] sta_hi_q;
   logic [15:0] sta_lo_q;
   logic [15:0] max_q;
   logic [1:0]  drop_q;
   logic [1:0]  dcare_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sta_hi_q <= '0;
         sta_lo_q <= '0;
         max_q    <= MAXLEN_RST[15:0];
         drop_q   <= '0;
         dcare_q  <= {DCARE_RST[BC_BIT], DCARE_RST[MC_BIT]};
      end else if (cfg_wr) begin
         case (cfg_addr)
            CFG_STA_HI: sta_hi_q <= cfg_wdata;
            CFG_STA_LO: sta_lo_q <= cfg_wdata[31:16];
            CFG_MAXLEN: max_q    <= cfg_wdata[15:0];
            CFG_DROP:   drop_q   <= {cfg_wdata[BC_BIT], cfg_wdata[MC_BIT]};
            CFG_DCARE:  dcare_q  <= {cfg_wdata[BC_BIT], cfg_wdata[MC_BIT]};
            default: ;
         endcase
      end
   end

   assign station = {sta_hi_q, sta_lo_q};
   assign max_len = max_q;
   assign drop_en = drop_q;
   assign dcare   = dcare_q;

   // R2: station words land where the octet mapping says
   a_r2_sta_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == CFG_STA_HI) |=> (station[47:16] == $past(cfg_wdata)));

endmodule

// File: rtl/rxf_frame_track.sv
module rxf_frame_track #(
   parameter int LEN_W      = 17,
   parameter int ADDR_BYTES = 6,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [7:0]              in_data,
   input  logic                    in_sop,
   input  logic                    in_eop,
   output logic [8*ADDR_BYTES-1:0] addr_next,
   output logic                    hdr_hit,
   output logic                    end_hit,
   output logic [LEN_W-1:0]        len_next,
   output logic [LEN_W-1:0]        len_q
);
   logic             open_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] cnt_inc;
   logic [LEN_W-1:0] pos;
   logic             take;

   assign take = in_valid && (in_sop || open_q);
   assign pos  = in_sop ? '0 : cnt_q;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt_q + 1'b1;
      end
   endgenerate

   assign len_next = in_sop ? LEN_W'(1) : cnt_inc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else if (take) begin
         open_q <= !in_eop;
         cnt_q  <= len_next;
      end
   end

   generate
      for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
         logic       hit;
         logic [7:0] q;
         assign hit = take && (pos == LEN_W'(b));
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= in_data;
         end
         assign addr_next[8*(ADDR_BYTES-b)-1 -: 8] = hit ? in_data : q;
      end
   endgenerate

   assign hdr_hit = take && (pos == LEN_W'(ADDR_BYTES - 1));
   assign end_hit = take && in_eop;
   assign len_q   = cnt_q;

endmodule

// File: rtl/rxf_addr_class.sv
module rxf_addr_class
   import rxf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [47:0] addr,
   input  logic [47:0] station,
   input  logic [1:0]  drop_en,
   input  logic [1:0]  dcare,
   output logic        pass,
   output rxf_kind_e   kind
);
   logic is_bc, is_mc, bc_ok, mc_ok, uni_ok;

   assign is_bc  = &addr;
   assign is_mc  = addr[40] && !is_bc;
   assign bc_ok  = !(drop_en[1] && !dcare[1]);
   assign mc_ok  = !(drop_en[0] && !dcare[0]);
   assign uni_ok = (addr == station);

   // broadcast is tested first (R6)
   always_comb begin
      if (is_bc) begin
         pass = bc_ok;
         kind = KIND_BCAST;
      end else if (is_mc) begin
         pass = mc_ok;
         kind = KIND_MULTI;
      end else begin
         pass = uni_ok;
         kind = KIND_UNI;
      end
   end

   // R4: broadcast don't-care overrides any drop setting
   a_r4_bc_dcare: assert property (@(posedge clk) disable iff (!rst_n)
      ((&addr) && dcare[1]) |-> pass);

   // R5: multicast with drop set and don't-care clear never passes
   a_r5_mc_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[40] && !(&addr) && drop_en[0] && !dcare[0]) |-> !pass);

endmodule

// File: rtl/rxf_dst_filter.sv
module rxf_dst_filter #(
   parameter int          LEN_W      = 17,
   parameter logic [31:0] MAXLEN_RST = 32'h0000_0600,
   parameter logic [31:0] DCARE_RST  = 32'h0003_FFFF,
   parameter int          BC_BIT     = 9,
   parameter int          MC_BIT     = 8,
   parameter bit          SATURATE   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [2:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   input  logic        in_sop,
   input  logic        in_eop,
   output logic        hdr_vld,
   output logic        hdr_pass,
   output logic        dec_vld,
   output logic        dec_pass,
   output logic [1:0]  dec_kind
);
   import rxf_pkg::*;

   localparam int ADDR_BYTES = 6;
   localparam int ADDR_W     = 8 * ADDR_BYTES;

   generate
      if (LEN_W < 16 || LEN_W > 32) begin : g_bad_len
         $error("LEN_W must lie in 16..32");
      end
      if (BC_BIT == MC_BIT || BC_BIT > 31 || MC_BIT > 31 || BC_BIT < 0 || MC_BIT < 0) begin : g_bad_bits
         $error("policy bit positions must be distinct and within a word");
      end
   endgenerate

   logic [ADDR_W-1:0] station, addr_next;
   logic [15:0]       max_len;
   logic [1:0]        drop_en, dcare;
   logic              hdr_hit, end_hit, cls_pass;
   logic [LEN_W-1:0]  len_next, len_q, limit;
   rxf_kind_e         cls_kind;
   logic              len_ok;

   rxf_cfg_regs #(
      .MAXLEN_RST(MAXLEN_RST), .DCARE_RST(DCARE_RST),
      .BC_BIT(BC_BIT), .MC_BIT(MC_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .station(station), .max_len(max_len),
      .drop_en(drop_en), .dcare(dcare)
   );

   rxf_frame_track #(
      .LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES), .SATURATE(SATURATE)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .addr_next(addr_next),
      .hdr_hit(hdr_hit), .end_hit(end_hit), .len_next(len_next), .len_q(len_q)
   );

   rxf_addr_class u_class (
      .clk(clk), .rst_n(rst_n), .addr(addr_next), .station(station),
      .drop_en(drop_en), .dcare(dcare), .pass(cls_pass), .kind(cls_kind)
   );

   assign limit  = LEN_W'(max_len);
   assign len_ok = (len_next >= LEN_W'(ADDR_BYTES)) && (len_next <= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_vld  <= 1'b0;
         hdr_pass <= 1'b0;
         dec_vld  <= 1'b0;
         dec_pass <= 1'b0;
         dec_kind <= KIND_UNI;
      end else begin
         hdr_vld  <= hdr_hit;
         hdr_pass <= hdr_hit && cls_pass;
         dec_vld  <= end_hit;
         dec_pass <= end_hit && cls_pass && len_ok;
         dec_kind <= end_hit ? cls_kind : KIND_UNI;
      end
   end

   // R7: an accepted frame never exceeds the limit
   a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && len_q > limit) |-> !dec_pass);

   // R8: short frames are always dropped
   a_r8_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && len_q < LEN_W'(ADDR_BYTES)) |-> !dec_pass);

   // R9: the header strobe is a single-cycle pulse
   a_r9_hdr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_vld |=> !hdr_vld);

   // R11: no byte offered means no strobe in the next cycle
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!hdr_vld && !dec_vld));

endmodule

// File: tb/sim_rxf_dst_filter.sv
module sim_rxf_dst_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        hdr_vld, hdr_pass, dec_vld, dec_pass;
   logic [1:0]  dec_kind;

   always #10 clk = ~clk;   // 50 MHz

   rxf_dst_filter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
      .in_sop(in_sop), .in_eop(in_eop), .hdr_vld(hdr_vld), .hdr_pass(hdr_pass),
      .dec_vld(dec_vld), .dec_pass(dec_pass), .dec_kind(dec_kind)
   );

   int checks = 0, errors = 0;
   int drv_idx = 0;
   int hdr_cnt, hdr_at, dec_cnt, dec_at;
   logic hdr_p, dec_p;
   logic [1:0] dec_k;

   localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

   // {dst, len, drop[bc,mc], dcare[bc,mc], pass, kind}
   localparam int NV = 11;
   localparam logic [70:0] VEC [NV] = '{
      {STA,                 16'd64, 2'b00, 2'b11, 1'b1, 2'd0},  // R3 match
      {48'h02_11_22_33_44_54, 16'd64, 2'b00, 2'b11, 1'b0, 2'd0},  // R3 last octet differs
      {48'h06_11_22_33_44_55, 16'd64, 2'b00, 2'b11, 1'b0, 2'd0},  // R3 first octet differs
      {48'hFF_FF_FF_FF_FF_FF, 16'd64, 2'b10, 2'b11, 1'b1, 2'd2},  // R4 don't-care wins
      {48'hFF_FF_FF_FF_FF_FF, 16'd64, 2'b10, 2'b00, 1'b0, 2'd2},  // R4 dropped
      {48'hFF_FF_FF_FF_FF_FF, 16'd64, 2'b01, 2'b00, 1'b1, 2'd2},  // R6 multicast bits ignored
      {48'h01_00_5E_00_00_01, 16'd64, 2'b01, 2'b00, 1'b0, 2'd1},  // R5 dropped
      {48'h01_00_5E_00_00_01, 16'd64, 2'b01, 2'b01, 1'b1, 2'd1},  // R5 don't-care wins
      {48'h01_00_5E_00_00_01, 16'd64, 2'b10, 2'b00, 1'b1, 2'd1},  // R5 broadcast bits ignored
      {48'hFF_FF_FF_FF_FF_FE, 16'd64, 2'b10, 2'b00, 1'b1, 2'd1},  // R6 near-broadcast is multicast
      {STA,                 16'd6,  2'b00, 2'b11, 1'b1, 2'd0}   // R8 six bytes is enough
   };

   always @(posedge clk) begin
      #5;
      if (hdr_vld) begin hdr_cnt++; hdr_at = drv_idx; hdr_p = hdr_pass; end
      if (dec_vld) begin dec_cnt++; dec_at = drv_idx; dec_p = dec_pass; dec_k = dec_kind; end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send(input logic [47:0] dst, input int len, input bit sop);
      hdr_cnt = 0; dec_cnt = 0; hdr_at = 0; dec_at = 0;
      hdr_p = 0; dec_p = 0; dec_k = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = (i < 6) ? dst[47 - 8*i -: 8] : 8'(i);
         in_sop   = sop && (i == 0);
         in_eop   = (i == len - 1);
         drv_idx  = i + 1;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic frame_check(input logic [47:0] dst, input int len, input bit pass,
                              input logic [1:0] kind, input string tag);
      send(dst, len, 1'b1);
      check(dec_cnt == 1, {tag, " final strobe count"}, dec_cnt, 1);
      check(dec_p == pass, {tag, " verdict"}, dec_p, pass);
      if (len >= 6) begin
         check(dec_k == kind, {tag, " kind R10"}, dec_k, kind);
         check(hdr_cnt == 1 && hdr_at == 6, {tag, " header timing R9"}, hdr_at, 6);
         check(dec_at == len, {tag, " final timing R9"}, dec_at, len);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs after reset
      check(!hdr_vld && !dec_vld && !dec_pass, "R1 idle outputs", {hdr_vld, dec_vld, dec_pass}, 0);
      // R1: station resets to zero
      frame_check(48'h0, 64, 1'b1, 2'd0, "R1 zero station");
      // R1: don't-care resets set, so drop bits alone do nothing
      cfg_write(3'd3, 32'h0000_0300);
      frame_check(48'hFF_FF_FF_FF_FF_FF, 64, 1'b1, 2'd2, "R1 bcast default");
      frame_check(48'h01_00_5E_00_00_07, 64, 1'b1, 2'd1, "R1 mcast default");
      // R1/R7: default limit 0x600
      frame_check(48'h0, 1536, 1'b1, 2'd0, "R1 len at default limit");
      frame_check(48'h0, 1537, 1'b0, 2'd0, "R7 len over default limit");

      // R2: station octet mapping
      cfg_write(3'd0, STA[47:16]);
      cfg_write(3'd1, {STA[15:0], 16'hA5A5});
      for (int v = 0; v < NV; v++) begin
         logic [70:0] e;
         e = VEC[v];
         cfg_write(3'd3, {22'd0, e[6:5], 8'd0});
         cfg_write(3'd4, {22'd0, e[4:3], 8'd0});
         frame_check(e[70:23], int'(e[22:7]), e[2], e[1:0], $sformatf("R2/vec%0d", v));
         check(hdr_p == e[2], "R3 header verdict", hdr_p, e[2]);
      end

      // R7: programmed limit, only bits [15:0] count
      cfg_write(3'd2, 32'h0001_0064);
      frame_check(STA, 100, 1'b1, 2'd0, "R7 len equals limit");
      frame_check(STA, 101, 1'b0, 2'd0, "R7 len one over limit");
      check(hdr_p == 1'b1, "R7 header passes before length known", hdr_p, 1);

      // R8: short frame
      frame_check(STA, 5, 1'b0, 2'd0, "R8 five bytes");
      check(hdr_cnt == 0, "R8 no header strobe", hdr_cnt, 0);

      // R11: bytes without a start marker
      send(STA, 12, 1'b0);
      check(hdr_cnt == 0 && dec_cnt == 0, "R11 stray bytes ignored", hdr_cnt + dec_cnt, 0);
      frame_check(STA, 20, 1'b1, 2'd0, "R11 next frame normal");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule